// File: doc/BRIEF.md
# DSD Bitstream Validity Monitor

This block sits on a two-channel 1-bit direct-stream-digital path (channels A and B) and judges whether the incoming bitstream looks like real audio. Each routed channel is checked for two faults. A *stuck* fault is a long run of one bit value. An *invalid* fault is a recent window in which one bit value strongly dominates. A stuck fault mutes the output with a DSD silence pattern until the run breaks. Both fault kinds raise sticky status flags, which a controller clears by pulsing a clear input.

Before the data is checked or output, a routing stage applies per-channel polarity inversion, an A/B swap and a copy of one channel onto both. Bits arrive on a base tick that runs at the fast rate (128×Fs). A rate selector either accepts every tick or, at 64×Fs, every second tick. A master enable gates the whole path. While it is low the detectors, counters and windows are held cleared.

A four-state controller sequences the path. IDLE is the state while disabled. FILL is entered on enable and lasts until the window holds 28 bits. WATCH is normal monitoring. MUTED is entered on a stuck run. The transitions are:
- IDLE→FILL when enabled.
- FILL→WATCH when the window fills.
- FILL→MUTED or WATCH→MUTED on a stuck bit while stuck detection is on.
- MUTED→WATCH on a run-breaking bit, or when stuck detection is turned off.
- any state→IDLE when disabled.

Top module: `dsd_stream_guard`

## Requirements
- R1: While `play_en` is high with `rate_fast`=1, every `base_tick` accepts one bit pair. With `rate_fast`=0, the first tick after enable is accepted and then every second tick. Each accepted pair appears on `dout_a`/`dout_b` one clock later, with `dout_vld` high for one cycle. Rejected ticks give no `dout_vld`.
- R2: Routing: A'=din_a^inv_a and B'=din_b^inv_b. Routed A = swap_ab ? B' : A'. Routed B = copy_ab ? routed A : (swap_ab ? A' : B'). Copy therefore overrides swap for channel B.
- R3: With `stuck_en`=1, once either routed channel has carried 28 consecutive equal bits (all 0 or all 1), that bit and every later accepted bit is replaced on both outputs by the silence pattern 1,0,1,0… (starting with 1), and `mute` is high. The first accepted bit that breaks the run is output as data, and `mute` falls with it.
- R4: `stuck_sts` is set on every accepted bit that finds a channel stuck while `stuck_en`=1. It stays set until a `clr_stuck` pulse, and a pulse while the run persists is overridden on the next stuck bit.
- R5: With `inval_en`=1, a channel is flagged when its last 28 routed bits hold at least 25 ones or at least 25 zeros. A window with 24 of one value is not flagged.
- R6: Invalid faults set `inval_a_sts` and `inval_b_sts` separately. Each flag is sticky and is cleared only by its own clear pulse.
- R7: With `stuck_en`=0 there is no mute and no stuck status. With `inval_en`=0 no invalid flag is set.
- R8: While `play_en` is low, `dout_vld` and `mute` are 0 and the run counters and windows are emptied. Status flags keep their values.
- R9: No invalid flag is raised before 28 bits have been accepted since the last enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_en | input | 1 | Master enable of the DSD path |
| rate_fast | input | 1 | 1: accept every base tick (128×Fs), 0: every second tick (64×Fs) |
| base_tick | input | 1 | Bit clock enable at the fast rate |
| din_a | input | 1 | Channel A input bit |
| din_b | input | 1 | Channel B input bit |
| inv_a | input | 1 | Invert channel A |
| inv_b | input | 1 | Invert channel B |
| swap_ab | input | 1 | Exchange channels |
| copy_ab | input | 1 | Drive routed A onto both channels |
| stuck_en | input | 1 | Enable stuck-run detection and muting |
| inval_en | input | 1 | Enable majority-window detection |
| clr_stuck | input | 1 | Clear pulse for the stuck flag |
| clr_inval_a | input | 1 | Clear pulse for the channel A invalid flag |
| clr_inval_b | input | 1 | Clear pulse for the channel B invalid flag |
| dout_a | output | 1 | Channel A output bit |
| dout_b | output | 1 | Channel B output bit |
| dout_vld | output | 1 | Output bit strobe |
| mute | output | 1 | Silence pattern is being driven |
| stuck_sts | output | 1 | Sticky stuck-fault flag |
| inval_a_sts | output | 1 | Sticky channel A invalid flag |
| inval_b_sts | output | 1 | Sticky channel B invalid flag |

## Verification
The hardest situation to reach is the majority boundary: a full 28-bit window that holds exactly 25 or exactly 24 of one value while no run ever reaches 28. Stimulus with periodic patterns reaches it. One channel carries three spread zeros per 28-bit period and the other carries four, so one channel sits at the threshold and the other just below it. Inverting a channel then checks the zero-dominated side. Stuck runs reach their length on one channel while the other alternates, including through the swap path. This shows that detection follows routing.

// File: rtl/dsd_guard_pkg.sv
package dsd_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WATCH,
        ST_MUTED
    } guard_st_e;

    typedef struct packed {
        logic a;
        logic b;
    } bit_pair_t;

endpackage

// File: rtl/dsd_route.sv
module dsd_route
    import dsd_guard_pkg::*;
(
    input  bit_pair_t raw,
    input  logic      inv_a,
    input  logic      inv_b,
    input  logic      swap_ab,
    input  logic      copy_ab,
    output bit_pair_t routed
);

    logic pol_a;
    logic pol_b;

    always_comb begin
        pol_a    = raw.a ^ inv_a;
        pol_b    = raw.b ^ inv_b;
        routed.a = swap_ab ? pol_b : pol_a;
        if (copy_ab) begin
            routed.b = routed.a;
        end else begin
            routed.b = swap_ab ? pol_a : pol_b;
        end
    end

endmodule

// File: rtl/dsd_chan_mon.sv
module dsd_chan_mon #(
    parameter int RUN_LEN = 28,
    parameter int WIN_LEN = 28,
    parameter int WIN_HI  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic take,
    input  logic bit_in,
    output logic stuck_nx,
    output logic inval_nx,
    output logic full_nx
);

    localparam int RW = $clog2(RUN_LEN + 1);
    localparam int CW = $clog2(WIN_LEN + 1);
    localparam logic [RW-1:0] RUN_C = RW'(RUN_LEN);
    localparam logic [CW-1:0] WIN_C = CW'(WIN_LEN);
    localparam logic [CW-1:0] HI_C  = CW'(WIN_HI);
    localparam logic [CW-1:0] LO_C  = CW'(WIN_LEN - WIN_HI);

    logic [RW-1:0]      run_q, run_d;
    logic               last_q;
    logic [WIN_LEN-1:0] win_q;
    logic [CW-1:0]      pop_q, pop_d;
    logic [CW-1:0]      seen_q, seen_d;

    always_comb begin
        seen_d = seen_q;
        run_d  = run_q;
        pop_d  = pop_q;
        if (take) begin
            if (seen_q < WIN_C) begin
                seen_d = seen_q + 1'b1;
            end
            if (seen_q == '0 || bit_in != last_q) begin
                run_d = RW'(1);
            end else if (run_q != RUN_C) begin
                run_d = run_q + 1'b1;
            end
            pop_d = pop_q + {{(CW-1){1'b0}}, bit_in}
                          - {{(CW-1){1'b0}}, win_q[WIN_LEN-1]};
        end
        full_nx  = (seen_d == WIN_C);
        stuck_nx = (run_d == RUN_C);
        inval_nx = take && full_nx && (pop_d >= HI_C || pop_d <= LO_C);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            run_q  <= '0;
            last_q <= 1'b0;
            win_q  <= '0;
            pop_q  <= '0;
            seen_q <= '0;
        end else if (take) begin
            run_q  <= run_d;
            last_q <= bit_in;
            win_q  <= {win_q[WIN_LEN-2:0], bit_in};
            pop_q  <= pop_d;
            seen_q <= seen_d;
        end
    end

    AST_POP_MATCHES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_q == CW'($countones(win_q))); // R5

    AST_RUN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        take && !hold && seen_q != '0 && bit_in != last_q |=> run_q == RW'(1)); // R3

endmodule

// File: rtl/dsd_guard_ctrl.sv
module dsd_guard_ctrl
    import dsd_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       play_en,
    input  logic       take,
    input  bit_pair_t  routed,
    input  logic       stuck_en,
    input  logic       inval_en,
    input  logic [1:0] stuck_nx,
    input  logic [1:0] inval_nx,
    input  logic       full_nx,
    input  logic       clr_stuck,
    input  logic       clr_inval_a,
    input  logic       clr_inval_b,
    output logic       dout_a,
    output logic       dout_b,
    output logic       dout_vld,
    output logic       mute,
    output logic       stuck_sts,
    output logic       inval_a_sts,
    output logic       inval_b_sts
);

    guard_st_e state_q, state_d;
    logic      sil_q;
    logic      stuck_hit;
    logic      mute_d;

    assign stuck_hit = take && stuck_en && (|stuck_nx);
    assign mute_d    = (state_d == ST_MUTED);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (play_en) state_d = ST_FILL;
            ST_FILL: begin
                if (stuck_hit)             state_d = ST_MUTED;
                else if (take && full_nx)  state_d = ST_WATCH;
            end
            ST_WATCH: if (stuck_hit) state_d = ST_MUTED;
            ST_MUTED: begin
                if (!stuck_en)                  state_d = ST_WATCH;
                else if (take && !(|stuck_nx))  state_d = ST_WATCH;
            end
        endcase
        if (!play_en) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_a      <= 1'b0;
            dout_b      <= 1'b0;
            dout_vld    <= 1'b0;
            mute        <= 1'b0;
            sil_q       <= 1'b1;
            stuck_sts   <= 1'b0;
            inval_a_sts <= 1'b0;
            inval_b_sts <= 1'b0;
        end else begin
            stuck_sts   <= (stuck_sts & ~clr_stuck) | stuck_hit;
            inval_a_sts <= (inval_a_sts & ~clr_inval_a) | (inval_en & inval_nx[0]);
            inval_b_sts <= (inval_b_sts & ~clr_inval_b) | (inval_en & inval_nx[1]);
            mute        <= mute_d;
            dout_vld    <= take;
            if (!play_en) begin
                dout_a <= 1'b0;
                dout_b <= 1'b0;
                sil_q  <= 1'b1;
            end else if (take) begin
                if (mute_d) begin
                    dout_a <= sil_q;
                    dout_b <= sil_q;
                    sil_q  <= ~sil_q;
                end else begin
                    dout_a <= routed.a;
                    dout_b <= routed.b;
                    sil_q  <= 1'b1;
                end
            end
        end
    end

    AST_NO_MUTE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !stuck_en |=> !mute); // R7

    AST_STUCK_STS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_sts && !clr_stuck |=> stuck_sts); // R4

    AST_MUTE_RAISES_STS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute) |-> stuck_sts); // R4

    AST_SILENCE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld && mute |-> dout_a == dout_b); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> !dout_vld && !mute); // R8

    AST_INVAL_A_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inval_a_sts) |-> $past(inval_en)); // R7

endmodule

// File: rtl/dsd_stream_guard.sv
module dsd_stream_guard
    import dsd_guard_pkg::*;
#(
    parameter int RUN_LEN = 28,
    parameter int WIN_LEN = 28,
    parameter int WIN_HI  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic play_en,
    input  logic rate_fast,
    input  logic base_tick,
    input  logic din_a,
    input  logic din_b,
    input  logic inv_a,
    input  logic inv_b,
    input  logic swap_ab,
    input  logic copy_ab,
    input  logic stuck_en,
    input  logic inval_en,
    input  logic clr_stuck,
    input  logic clr_inval_a,
    input  logic clr_inval_b,
    output logic dout_a,
    output logic dout_b,
    output logic dout_vld,
    output logic mute,
    output logic stuck_sts,
    output logic inval_a_sts,
    output logic inval_b_sts
);

    localparam int NCH = 2;

    logic            half_q;
    logic            take;
    bit_pair_t       raw;
    bit_pair_t       routed;
    logic [NCH-1:0]  ch_bits;
    logic [NCH-1:0]  stuck_nx;
    logic [NCH-1:0]  inval_nx;
    logic [NCH-1:0]  full_nx;

    assign take = play_en && base_tick && (rate_fast || !half_q);

    always_ff @(posedge clk) begin
        if (!rst_n || !play_en) half_q <= 1'b0;
        else if (base_tick)     half_q <= ~half_q;
    end

    assign raw.a   = din_a;
    assign raw.b   = din_b;
    assign ch_bits = {routed.b, routed.a};

    dsd_route i_route (
        .raw     (raw),
        .inv_a   (inv_a),
        .inv_b   (inv_b),
        .swap_ab (swap_ab),
        .copy_ab (copy_ab),
        .routed  (routed)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_mon
        dsd_chan_mon #(
            .RUN_LEN (RUN_LEN),
            .WIN_LEN (WIN_LEN),
            .WIN_HI  (WIN_HI)
        ) i_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (!play_en),
            .take     (take),
            .bit_in   (ch_bits[g]),
            .stuck_nx (stuck_nx[g]),
            .inval_nx (inval_nx[g]),
            .full_nx  (full_nx[g])
        );
    end

    dsd_guard_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .play_en     (play_en),
        .take        (take),
        .routed      (routed),
        .stuck_en    (stuck_en),
        .inval_en    (inval_en),
        .stuck_nx    (stuck_nx),
        .inval_nx    (inval_nx),
        .full_nx     (full_nx[0]),
        .clr_stuck   (clr_stuck),
        .clr_inval_a (clr_inval_a),
        .clr_inval_b (clr_inval_b),
        .dout_a      (dout_a),
        .dout_b      (dout_b),
        .dout_vld    (dout_vld),
        .mute        (mute),
        .stuck_sts   (stuck_sts),
        .inval_a_sts (inval_a_sts),
        .inval_b_sts (inval_b_sts)
    );

    AST_FULL_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        full_nx[0] == full_nx[1]); // R9

    AST_SLOW_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        play_en && !rate_fast && take |=> !take); // R1

endmodule

// File: tb/test_dsd_stream_guard.sv
module test_dsd_stream_guard;

    logic clk = 1'b0;
    logic rst_n;
    logic play_en, rate_fast, base_tick, din_a, din_b;
    logic inv_a, inv_b, swap_ab, copy_ab, stuck_en, inval_en;
    logic clr_stuck, clr_inval_a, clr_inval_b;
    logic dout_a, dout_b, dout_vld, mute, stuck_sts, inval_a_sts, inval_b_sts;

    int n_chk = 0;
    int n_err = 0;

    // reference state
    int          m_run [2];
    logic        m_last [2];
    logic [27:0] m_win [2];
    int          m_seen;
    logic        m_sil, m_ph;
    logic        e_a, e_b, e_mute, e_stuck, e_inva, e_invb;

    always #5 clk = ~clk;

    dsd_stream_guard i_dsd_stream_guard (
        .clk(clk), .rst_n(rst_n), .play_en(play_en), .rate_fast(rate_fast),
        .base_tick(base_tick), .din_a(din_a), .din_b(din_b),
        .inv_a(inv_a), .inv_b(inv_b), .swap_ab(swap_ab), .copy_ab(copy_ab),
        .stuck_en(stuck_en), .inval_en(inval_en), .clr_stuck(clr_stuck),
        .clr_inval_a(clr_inval_a), .clr_inval_b(clr_inval_b),
        .dout_a(dout_a), .dout_b(dout_b), .dout_vld(dout_vld), .mute(mute),
        .stuck_sts(stuck_sts), .inval_a_sts(inval_a_sts), .inval_b_sts(inval_b_sts)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            m_run[c] = 0; m_last[c] = 1'b0; m_win[c] = '0;
        end
        m_seen = 0; m_sil = 1'b1; m_ph = 1'b0; e_mute = 1'b0;
    endtask

    task automatic check_sts(input string req);
        chk(stuck_sts === e_stuck, {req, " stuck_sts"}, int'(stuck_sts), int'(e_stuck));
        chk(inval_a_sts === e_inva, {req, " R6 inval_a_sts"}, int'(inval_a_sts), int'(e_inva));
        chk(inval_b_sts === e_invb, {req, " R6 inval_b_sts"}, int'(inval_b_sts), int'(e_invb));
    endtask

    task automatic send(input logic a, input logic b, input string req);
        logic acc, pa, pb, ra, rb, stk;
        logic bits [2];
        acc = rate_fast || !m_ph;
        m_ph = ~m_ph;
        din_a = a; din_b = b; base_tick = 1'b1;
        if (acc) begin
            pa = a ^ inv_a; pb = b ^ inv_b;
            ra = swap_ab ? pb : pa;
            rb = copy_ab ? ra : (swap_ab ? pa : pb);
            bits[0] = ra; bits[1] = rb;
            for (int c = 0; c < 2; c++) begin
                if (m_seen == 0 || bits[c] != m_last[c]) m_run[c] = 1;
                else if (m_run[c] < 28) m_run[c]++;
                m_last[c] = bits[c];
                m_win[c] = {m_win[c][26:0], bits[c]};
            end
            if (m_seen < 28) m_seen++;
            stk = (m_run[0] >= 28) || (m_run[1] >= 28);
            e_mute = stuck_en && stk;
            if (e_mute) begin
                e_a = m_sil; e_b = m_sil; m_sil = ~m_sil; e_stuck = 1'b1;
            end else begin
                e_a = ra; e_b = rb; m_sil = 1'b1;
            end
            if (inval_en && m_seen == 28) begin
                if ($countones(m_win[0]) >= 25 || $countones(m_win[0]) <= 3) e_inva = 1'b1;
                if ($countones(m_win[1]) >= 25 || $countones(m_win[1]) <= 3) e_invb = 1'b1;
            end
        end
        @(negedge clk);
        base_tick = 1'b0;
        chk(dout_vld === acc, {req, " R1 dout_vld"}, int'(dout_vld), int'(acc));
        if (acc) begin
            chk(dout_a === e_a, {req, " dout_a"}, int'(dout_a), int'(e_a));
            chk(dout_b === e_b, {req, " dout_b"}, int'(dout_b), int'(e_b));
        end
        chk(mute === e_mute, {req, " mute"}, int'(mute), int'(e_mute));
        check_sts(req);
    endtask

    task automatic restart();
        play_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        model_clear();
        chk(dout_vld === 1'b0 && mute === 1'b0, "R8 disabled quiet", int'({dout_vld, mute}), 0);
        check_sts("R8 status kept");
        play_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_stuck = 1'b1; clr_inval_a = 1'b1; clr_inval_b = 1'b1;
        @(negedge clk);
        clr_stuck = 1'b0; clr_inval_a = 1'b0; clr_inval_b = 1'b0;
        e_stuck = 1'b0; e_inva = 1'b0; e_invb = 1'b0;
        check_sts("R6 clear");
    endtask

    initial begin : watchdog
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0; play_en = 1'b0; rate_fast = 1'b1; base_tick = 1'b0;
        din_a = 1'b0; din_b = 1'b0; inv_a = 1'b0; inv_b = 1'b0;
        swap_ab = 1'b0; copy_ab = 1'b0; stuck_en = 1'b1; inval_en = 1'b0;
        clr_stuck = 1'b0; clr_inval_a = 1'b0; clr_inval_b = 1'b0;
        e_a = 1'b0; e_b = 1'b0; e_stuck = 1'b0; e_inva = 1'b0; e_invb = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_vld === 1'b0 && mute === 1'b0 && dout_a === 1'b0, "R8 reset outputs",
            int'({dout_vld, mute, dout_a}), 0);
        check_sts("R4 reset");
        play_en = 1'b1;
        @(negedge clk);

        // R2 routing sweep over all control combinations and input pairs
        for (int cfg = 0; cfg < 16; cfg++) begin
            inv_a = cfg[0]; inv_b = cfg[1]; swap_ab = cfg[2]; copy_ab = cfg[3];
            for (int k = 0; k < 4; k++) send(k[0], k[1], "R2 routing");
        end
        inv_a = 1'b0; inv_b = 1'b0; swap_ab = 1'b0; copy_ab = 1'b0;
        restart();

        // R3 stuck zeros on A, B alternating; release on break
        for (int i = 0; i < 31; i++) send(1'b0, i[0], "R3 stuck zeros");
        send(1'b1, 1'b0, "R3 release");
        send(1'b0, 1'b1, "R3 after release");
        clear_all();

        // R3 stuck ones arriving on B, routed to A by swap
        swap_ab = 1'b1;
        for (int i = 0; i < 30; i++) send(i[0], 1'b1, "R3 swap stuck ones");
        clr_stuck = 1'b1;
        @(negedge clk);
        clr_stuck = 1'b0;
        e_stuck = 1'b0;
        check_sts("R4 clear while stuck");
        send(1'b0, 1'b1, "R4 reassert");
        send(1'b0, 1'b0, "R3 break");
        swap_ab = 1'b0;
        clear_all();

        // R7 stuck detection off
        stuck_en = 1'b0;
        for (int i = 0; i < 32; i++) send(1'b1, 1'b1, "R7 stuck off");
        stuck_en = 1'b1;
        restart();

        // R5 / R9 majority window: A 25 ones per 28, B 24 ones per 28
        inval_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            int p;
            p = i % 28;
            send(!(p == 0 || p == 9 || p == 18), !(p == 0 || p == 7 || p == 14 || p == 21),
                 "R5 R9 window");
        end
        clear_all();
        // zero-dominated side on B through inversion
        inv_b = 1'b1;
        for (int i = 0; i < 40; i++) begin
            int p;
            p = i % 28;
            send(i[0], !(p == 2 || p == 11 || p == 20), "R5 zeros dominate");
        end
        inv_b = 1'b0;
        clear_all();
        // R7 invalid detection off
        inval_en = 1'b0;
        for (int i = 0; i < 30; i++) send(!(i % 9 == 0), 1'b0 ^ i[0], "R7 inval off");
        restart();

        // R1 slow rate
        rate_fast = 1'b0;
        for (int i = 0; i < 12; i++) send(i[1], i[2], "R1 slow rate");
        rate_fast = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule